// File: doc/BRIEF.md
# Infrared Remote Packet Transmitter

This block drives the infrared LED of a remote control for a toy car. From a single system clock it makes two slow rates with counter enables: a carrier of about 36 kHz and a packet trigger of 10 Hz. On every trigger it plays one fixed sequence of fields. Burst fields put the carrier square wave on the LED. Gap fields hold the LED dark. Each field length is a parameter given in whole carrier periods.

Four direction buttons (right, left, forward, backward) set the length of their own field. A pressed button gives a long burst and a released one gives a short burst. The button levels pass through a synchroniser and are captured once, at the start of each packet, so every packet reflects one consistent set of levels. Once the last gap is over the LED stays dark until the next trigger.

Top module: `ir_packet_tx`

## Requirements
- R1: While reset is asserted, and from reset release until the first packet starts, led_o is low. Asserting the asynchronous reset in the middle of a burst forces led_o low at once, and the packet timing restarts from the release.
- R2: A packet starts every PACKET_DIV system clocks. The first packet starts on the PACKET_DIV-th rising edge after reset release, and led_o is high in the clock cycle that follows that edge.
- R3: During a burst field, led_o is a square wave with a period of CARRIER_DIV clocks. It is high for the first CARRIER_DIV/2 clocks of each period, and its phase restarts at the start of every packet.
- R4: The fields run in the order Start, Gap, Select, Gap, Right, Gap, Left, Gap, Forward, Gap, Backward, Gap. Start lasts START_LEN carrier periods, Select lasts SEL_LEN and each Gap lasts GAP_LEN.
- R5: led_o is low for the whole of every Gap field.
- R6: btn_i bit 0 is right, bit 1 is left, bit 2 is forward and bit 3 is backward. A direction field lasts LONG_LEN carrier periods when its captured bit is 1 and SHORT_LEN periods when it is 0.
- R7: Button levels are captured once per packet, through a two-stage synchroniser, at the packet-start edge. A change of btn_i is captured if at least three rising edges, counting the start edge, follow it. A change with only two such edges is not captured. Changes made during a packet have no effect on that packet.
- R8: After the final Gap, led_o stays low until the next packet start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (100 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Raw button levels: right, left, forward, backward (bit 0 up) |
| led_o | output | 1 | LED drive: carrier during bursts, low otherwise |

## Verification
The hardest case to reach from the ports is a button change that lands right at the capture window. The two synchroniser stages decide whether the level reaches the packet that is about to start, and a change one edge too late must fall through to the following packet. The stimulus counts rising edges from reset release, so it knows exactly where each packet-start edge falls. It then changes btn_i two edges before a start and checks the high-cycle count of that packet and of the next one. Every table packet also flips the buttons shortly after its start. This shows that a change inside a packet leaves that packet unchanged, while a value restored in the idle tail is still picked up by the next packet.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int NUM_BTN   = 4;
  localparam int BTN_RIGHT = 0;
  localparam int BTN_LEFT  = 1;
  localparam int BTN_FWD   = 2;
  localparam int BTN_BACK  = 3;

  typedef enum logic [3:0] {
    FLD_IDLE   = 4'd0,
    FLD_START  = 4'd1,
    FLD_GAP_A  = 4'd2,
    FLD_SELECT = 4'd3,
    FLD_GAP_B  = 4'd4,
    FLD_RIGHT  = 4'd5,
    FLD_GAP_C  = 4'd6,
    FLD_LEFT   = 4'd7,
    FLD_GAP_D  = 4'd8,
    FLD_FWD    = 4'd9,
    FLD_GAP_E  = 4'd10,
    FLD_BACK   = 4'd11,
    FLD_GAP_F  = 4'd12
  } fld_e;

  // packet field order is protocol behaviour
  function automatic fld_e fld_next(fld_e f);
    case (f)
      FLD_START:  return FLD_GAP_A;
      FLD_GAP_A:  return FLD_SELECT;
      FLD_SELECT: return FLD_GAP_B;
      FLD_GAP_B:  return FLD_RIGHT;
      FLD_RIGHT:  return FLD_GAP_C;
      FLD_GAP_C:  return FLD_LEFT;
      FLD_LEFT:   return FLD_GAP_D;
      FLD_GAP_D:  return FLD_FWD;
      FLD_FWD:    return FLD_GAP_E;
      FLD_GAP_E:  return FLD_BACK;
      FLD_BACK:   return FLD_GAP_F;
      default:    return FLD_IDLE;
    endcase
  endfunction

  function automatic logic fld_is_gap(fld_e f);
    return f inside {FLD_GAP_A, FLD_GAP_B, FLD_GAP_C, FLD_GAP_D, FLD_GAP_E, FLD_GAP_F};
  endfunction

  function automatic logic fld_is_burst(fld_e f);
    return f inside {FLD_START, FLD_SELECT, FLD_RIGHT, FLD_LEFT, FLD_FWD, FLD_BACK};
  endfunction

endpackage

// File: rtl/ir_rate_gen.sv
module ir_rate_gen #(
  parameter int CARRIER_DIV = 2778,
  parameter int PACKET_DIV  = 10000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pkt_tick_o,
  output logic car_tick_o,
  output logic car_lvl_o
);

  localparam int CW   = $clog2(CARRIER_DIV);
  localparam int PW   = $clog2(PACKET_DIV);
  localparam int HALF = CARRIER_DIV / 2;

  logic [CW-1:0] cc_q;
  logic [PW-1:0] pc_q;
  logic          car_wrap;

  assign pkt_tick_o = (pc_q == PW'(PACKET_DIV - 1));
  assign car_wrap   = (cc_q == CW'(CARRIER_DIV - 1));
  assign car_tick_o = car_wrap && !pkt_tick_o;
  assign car_lvl_o  = (cc_q < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (pkt_tick_o) pc_q <= '0;
    else                 pc_q <= pc_q + PW'(1);
  end

  // carrier phase realigned on every packet start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cc_q <= '0;
    else if (pkt_tick_o || car_wrap) cc_q <= '0;
    else                             cc_q <= cc_q + CW'(1);
  end

endmodule

// File: rtl/ir_btn_sync.sv
module ir_btn_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ir_field_seq.sv
module ir_field_seq
  import ir_tx_pkg::*;
#(
  parameter int START_LEN = 16,
  parameter int SEL_LEN   = 8,
  parameter int GAP_LEN   = 4,
  parameter int LONG_LEN  = 12,
  parameter int SHORT_LEN = 4,
  parameter int CNT_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_tick_i,
  input  logic               car_tick_i,
  input  logic [NUM_BTN-1:0] btn_i,
  output fld_e               state_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [NUM_BTN-1:0] btn_lat_o,
  output logic               burst_o
);

  fld_e               state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_BTN-1:0] btn_lat_q;
  logic [CNT_W-1:0]   cur_len;
  logic               fld_done;

  function automatic logic [CNT_W-1:0] dir_len(logic pressed);
    return pressed ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
  endfunction

  always_comb begin
    case (state_q)
      FLD_START:  cur_len = CNT_W'(START_LEN);
      FLD_SELECT: cur_len = CNT_W'(SEL_LEN);
      FLD_RIGHT:  cur_len = dir_len(btn_lat_q[BTN_RIGHT]);
      FLD_LEFT:   cur_len = dir_len(btn_lat_q[BTN_LEFT]);
      FLD_FWD:    cur_len = dir_len(btn_lat_q[BTN_FWD]);
      FLD_BACK:   cur_len = dir_len(btn_lat_q[BTN_BACK]);
      FLD_IDLE:   cur_len = CNT_W'(1);
      default:    cur_len = CNT_W'(GAP_LEN);
    endcase
  end

  assign fld_done = (cnt_q == cur_len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FLD_IDLE;
      cnt_q     <= '0;
      btn_lat_q <= '0;
    end else if (pkt_tick_i) begin
      state_q   <= FLD_START;
      cnt_q     <= '0;
      btn_lat_q <= btn_i;
    end else if (car_tick_i && state_q != FLD_IDLE) begin
      if (fld_done) begin
        state_q <= fld_next(state_q);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign btn_lat_o = btn_lat_q;
  assign burst_o   = fld_is_burst(state_q);

endmodule

// File: rtl/ir_packet_tx.sv
module ir_packet_tx
  import ir_tx_pkg::*;
#(
  parameter int CARRIER_DIV = 2778,
  parameter int PACKET_DIV  = 10000000,
  parameter int START_LEN   = 16,
  parameter int SEL_LEN     = 8,
  parameter int GAP_LEN     = 4,
  parameter int LONG_LEN    = 12,
  parameter int SHORT_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic               led_o
);

  localparam int MAX_A   = (START_LEN > SEL_LEN) ? START_LEN : SEL_LEN;
  localparam int MAX_B   = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN = (MAX_C > GAP_LEN) ? MAX_C : GAP_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic               pkt_tick;
  logic               car_tick;
  logic               car_lvl;
  logic [NUM_BTN-1:0] btn_sync;
  fld_e               seq_state;
  logic [CNT_W-1:0]   seq_cnt;
  logic [NUM_BTN-1:0] btn_lat;
  logic               burst;

  ir_rate_gen #(
    .CARRIER_DIV (CARRIER_DIV),
    .PACKET_DIV  (PACKET_DIV)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_tick_o (pkt_tick),
    .car_tick_o (car_tick),
    .car_lvl_o  (car_lvl)
  );

  ir_btn_sync #(
    .WIDTH  (NUM_BTN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_i),
    .q_o    (btn_sync)
  );

  ir_field_seq #(
    .START_LEN (START_LEN),
    .SEL_LEN   (SEL_LEN),
    .GAP_LEN   (GAP_LEN),
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_tick_i (pkt_tick),
    .car_tick_i (car_tick),
    .btn_i      (btn_sync),
    .state_o    (seq_state),
    .cnt_o      (seq_cnt),
    .btn_lat_o  (btn_lat),
    .burst_o    (burst)
  );

  assign led_o = burst & car_lvl;

endmodule

// File: rtl/ir_packet_tx_chk.sv
module ir_packet_tx_chk
  import ir_tx_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int MAX_LEN = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               led_o,
  input logic               pkt_tick,
  input fld_e               state,
  input logic [CNT_W-1:0]   cnt,
  input logic [NUM_BTN-1:0] btn_lat
);

  assert_packet_kickoff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_tick |=> (state == FLD_START && cnt == '0));

  assert_led_only_in_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> fld_is_burst(state));

  assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(MAX_LEN));

  assert_gap_dark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_is_gap(state) |-> !led_o);

  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_tick |=> $stable(btn_lat));

  assert_idle_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == FLD_IDLE) |-> !led_o);

endmodule

bind ir_packet_tx ir_packet_tx_chk #(
  .CNT_W   (CNT_W),
  .MAX_LEN (MAX_LEN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .led_o    (led_o),
  .pkt_tick (pkt_tick),
  .state    (seq_state),
  .cnt      (seq_cnt),
  .btn_lat  (btn_lat)
);

// File: tb/ir_packet_tx_test.sv
`timescale 1ns/1ps
module ir_packet_tx_test;

  localparam int CD    = 4;
  localparam int HALF  = CD / 2;
  localparam int P     = 120;
  localparam int L_ST  = 3;
  localparam int L_SEL = 2;
  localparam int L_GAP = 1;
  localparam int L_LNG = 3;
  localparam int L_SHT = 1;
  localparam int NV    = 6;

  typedef struct packed {
    logic [3:0] btn;
    int         hi;
  } vec_t;

  // high clocks per packet = HALF * (start + select + four direction lengths)
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 18},
    '{4'b1111, 34},
    '{4'b0001, 22},
    '{4'b0110, 26},
    '{4'b1000, 22},
    '{4'b1010, 26}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] btn_i;
  logic       led_o;
  int         cyc;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk_i = ~clk_i;

  ir_packet_tx #(
    .CARRIER_DIV (CD),
    .PACKET_DIV  (P),
    .START_LEN   (L_ST),
    .SEL_LEN     (L_SEL),
    .GAP_LEN     (L_GAP),
    .LONG_LEN    (L_LNG),
    .SHORT_LEN   (L_SHT)
  ) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_i),
    .led_o  (led_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // returns category*2 + level; category 0 idle tail, 1 fixed burst, 2 gap, 3 direction
  function automatic int model(int t, logic [3:0] b);
    int acc = 0;
    for (int f = 0; f < 12; f++) begin
      int len;
      int cat;
      if (f % 2 == 1) begin len = L_GAP; cat = 2; end
      else if (f == 0) begin len = L_ST; cat = 1; end
      else if (f == 2) begin len = L_SEL; cat = 1; end
      else begin len = b[(f - 4) / 2] ? L_LNG : L_SHT; cat = 3; end
      len = len * CD;
      if (t < acc + len)
        return cat * 2 + ((cat != 2 && ((t - acc) % CD) < HALF) ? 1 : 0);
      acc += len;
    end
    return 0;
  endfunction

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int mm [4];
    int hi;
    int hi_k [3];
    int t;
    int k;
    int code;

    rst_ni = 1'b0;
    btn_i  = 4'b0000;
    repeat (3) @(negedge clk_i);
    chk(led_o == 1'b0, "R1 led low in reset", led_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) mm[i] = 0;
    hi = 0;

    // table walk: one packet per vector, buttons flipped mid packet
    for (int n = 1; n < (NV + 1) * P; n++) begin
      @(negedge clk_i);
      t = cyc % P;
      k = cyc / P;
      if (k == 0) begin
        if (led_o) mm[0]++;
        if (t == P - 20) btn_i = VEC[0].btn;
        if (t == P - 1) begin
          chk(mm[0] == 0, "R1 dark before first packet", mm[0], 0);
          chk(led_o == 1'b0, "R2 last idle cycle dark", led_o, 0);
          mm[0] = 0;
        end
      end else begin
        code = model(t, VEC[k-1].btn);
        if (led_o != code[0]) mm[code / 2]++;
        if (led_o) hi++;
        if (t == 0) chk(led_o == 1'b1, "R2 packet starts on schedule", led_o, 1);
        if (t == 5) btn_i = ~VEC[k-1].btn;
        if (t == P - 20 && k < NV) btn_i = VEC[k].btn;
        if (t == P - 1) begin
          chk(mm[1] == 0, "R4 start/select bursts", mm[1], 0);
          chk(mm[2] == 0, "R5 gaps dark", mm[2], 0);
          chk(mm[3] == 0, "R6 direction field lengths", mm[3], 0);
          chk(mm[0] == 0, "R8 dark after last gap", mm[0], 0);
          chk(hi == VEC[k-1].hi, "R3 R7 high clocks per packet", hi, VEC[k-1].hi);
          for (int i = 0; i < 4; i++) mm[i] = 0;
          hi = 0;
        end
      end
    end

    // directed: reset in the middle of a burst
    for (int n = 0; n < P && !led_o; n++) @(negedge clk_i);
    chk(led_o == 1'b1, "R1 reached a burst before reset", led_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(led_o == 1'b0, "R1 async reset darkens led", led_o, 0);
    btn_i = 4'b0000;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) hi_k[i] = 0;

    // directed: change two edges before start is missed, caught next packet
    for (int n = 1; n < 3 * P; n++) begin
      @(negedge clk_i);
      k = cyc / P;
      if (led_o) hi_k[k]++;
      if (cyc == P - 2) btn_i = 4'b1111;
      if (cyc == P) chk(led_o == 1'b1, "R1 R2 restart timing after reset", led_o, 1);
    end
    chk(hi_k[0] == 0, "R1 dark after mid-packet reset", hi_k[0], 0);
    chk(hi_k[1] == 18, "R7 late change not captured", hi_k[1], 18);
    chk(hi_k[2] == 34, "R7 change captured next packet", hi_k[2], 34);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule